// File: doc/BRIEF.md
# Tree Sum Reduction Sequencer

This block folds a bank of signed partial sums into a single total by running a halving reduction in hardware. Software or an upstream engine first fills the bank through a simple write port, one entry per cycle, then pulses start together with the number of participating lanes. The sequencer repeatedly halves an active range. Every lane in the lower half adds the matching entry from the upper half, and the lanes of one step all finish before the next step begins.

When the active count is odd, the last entry of the range would be stranded by the halving. Entry 0 absorbs it in a dedicated cycle before the pairwise adds of that step. The scheme therefore works for any lane count, not only powers of two. All additions wrap modulo the word width. When the range shrinks to one, entry 0 holds the total and a one-cycle done pulse is raised. The bank can then be read through a registered read port until the next start.

Top module: `tree_reduce_top`

## Requirements
- R1: After reset, busy and done are low and every entry reads 0. While the block is idle, a write with wr_en high stores wr_data in entry wr_idx. rd_data shows entry rd_idx as it stood at the previous clock edge, so it lags rd_idx by one cycle.
- R2: A start pulse while idle, with an effective count N of at least 2, latches N and raises busy from the next cycle until the reduction ends.
- R3: In every step whose current half value h is odd, entry 0 becomes entry 0 plus entry h-1. This happens in the step's first cycle, before any pairwise add of that step.
- R4: In the second cycle of each step, h is replaced by floor(h/2). Every lane i below the new h adds entry i+h, reading values from before that cycle. Each step takes exactly two cycles, so lane 0 is never written twice in one cycle.
- R5: When the reduction ends, entry 0 holds the sum of entries 0..N-1 modulo 2^W. Entries at index N and above are left untouched.
- R6: Done is high for exactly one cycle and busy is low in that cycle. Done becomes visible 2*S clock edges after the edge that samples start, where S is the number of halvings needed to bring N down to 1.
- R7: A start pulse or a write while busy is ignored. The running reduction, its latency and every bank entry are unaffected.
- R8: A lane count of 0 or 1 performs no addition. Done is raised right after the edge that samples start, busy stays low, and the bank is unchanged.
- R9: A lane count above LANES is clamped to LANES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, honoured only while idle |
| wr_idx | input | IW | Entry written |
| wr_data | input | W | Value written |
| lane_count | input | CW | Number of participating lanes, sampled at start |
| start | input | 1 | Start pulse, honoured only while idle |
| rd_idx | input | IW | Entry read |
| rd_data | output | W | Registered read data |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle pulse when entry 0 holds the total |

## Verification
The assertions assume that start is a pulse and that lane_count is only meaningful in the cycle start is sampled. They also assume that rst is held for at least one edge before the first start. The bench drives start for exactly one cycle and keeps rd_idx at 0 across each reduction, so the monitor's read of the total follows done directly. It deliberately toggles start, lane_count and the write port in the middle of a run to probe the ignore rule. It also uses counts that are odd, even, trivial, zero and over the bank size, plus values chosen to force wraparound.

// File: rtl/tr_pkg.sv
package tr_pkg;
  // Sequencer phases: idle, odd fix-up cycle, pairwise add cycle.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FIX  = 2'd1,
    ST_ADD  = 2'd2
  } tr_state_e;
endpackage

// File: rtl/tr_sequencer.sv
module tr_sequencer
  import tr_pkg::*;
#(
  parameter int LANES = 128,
  parameter int IW    = $clog2(LANES),
  parameter int CW    = IW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] lane_count,
  output logic          busy,
  output logic          done,
  output logic          fix_phase,
  output logic          fix_en,
  output logic [IW-1:0] fix_idx,
  output logic          add_en,
  output logic [CW-1:0] add_half,
  output logic [CW-1:0] half_q
);
  localparam logic [CW-1:0] LANES_C = CW'(LANES);
  localparam logic [CW-1:0] ONE_C   = CW'(1);

  tr_state_e     state_q;
  logic [CW-1:0] eff_count;

  // Clamp the requested count to the bank size (R9).
  always_comb begin
    eff_count = (lane_count > LANES_C) ? LANES_C : lane_count;
  end

  always_comb begin
    busy      = (state_q != ST_IDLE);
    fix_phase = (state_q == ST_FIX);
    fix_en    = fix_phase && half_q[0];
    fix_idx   = IW'(half_q - ONE_C);
    add_en    = (state_q == ST_ADD);
    add_half  = half_q >> 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      half_q  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (eff_count <= ONE_C) begin
              done <= 1'b1;            // trivial count (R8)
            end else begin
              half_q  <= eff_count;
              state_q <= ST_FIX;
            end
          end
        end
        ST_FIX: begin
          state_q <= ST_ADD;
        end
        ST_ADD: begin
          half_q <= add_half;
          if (add_half == ONE_C) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
          end else begin
            state_q <= ST_FIX;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tr_lane_bank.sv
module tr_lane_bank #(
  parameter int LANES = 128,
  parameter int W     = 32,
  parameter int IW    = $clog2(LANES),
  parameter int CW    = IW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ok,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic          fix_en,
  input  logic [IW-1:0] fix_idx,
  input  logic          add_en,
  input  logic [CW-1:0] add_half,
  output logic [W-1:0]  bank_q [LANES]
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [W-1:0]  nxt;
    logic [CW-1:0] pidx;
    logic          active;

    always_comb begin
      pidx   = CW'(i) + add_half;
      active = add_en && (CW'(i) < add_half);
    end

    if (i == 0) begin : g_head
      // Lane 0 also takes the odd fix-up, in a cycle of its own.
      always_comb begin
        nxt = bank_q[i];
        if (wr_ok && (wr_idx == IW'(i))) begin
          nxt = wr_data;
        end else if (active) begin
          nxt = bank_q[i] + bank_q[pidx[IW-1:0]];
        end else if (fix_en) begin
          nxt = bank_q[i] + bank_q[fix_idx];
        end
      end
    end else begin : g_body
      always_comb begin
        nxt = bank_q[i];
        if (wr_ok && (wr_idx == IW'(i))) begin
          nxt = wr_data;
        end else if (active) begin
          nxt = bank_q[i] + bank_q[pidx[IW-1:0]];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) bank_q[i] <= '0;
      else     bank_q[i] <= nxt;
    end
  end
endmodule

// File: rtl/tr_read_port.sv
module tr_read_port #(
  parameter int LANES = 128,
  parameter int W     = 32,
  parameter int IW    = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] rd_idx,
  input  logic [W-1:0]  bank_q [LANES],
  output logic [W-1:0]  rd_data
);
  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= bank_q[rd_idx];
  end
endmodule

// File: rtl/tree_reduce_top.sv
module tree_reduce_top #(
  parameter int LANES = 128,
  parameter int W     = 32,
  parameter int IW    = $clog2(LANES),
  parameter int CW    = IW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [CW-1:0] lane_count,
  input  logic          start,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  output logic          busy,
  output logic          done
);
  logic          fix_phase;
  logic          fix_en;
  logic [IW-1:0] fix_idx;
  logic          add_en;
  logic [CW-1:0] add_half;
  logic [CW-1:0] half_q;
  logic          wr_ok;
  logic [W-1:0]  bank_q [LANES];

  // Writes are dropped while a reduction runs (R7).
  assign wr_ok = wr_en && !busy;

  tr_sequencer #(.LANES(LANES), .IW(IW), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .lane_count(lane_count),
    .busy(busy), .done(done), .fix_phase(fix_phase), .fix_en(fix_en),
    .fix_idx(fix_idx), .add_en(add_en), .add_half(add_half), .half_q(half_q)
  );

  tr_lane_bank #(.LANES(LANES), .W(W), .IW(IW), .CW(CW)) u_bank (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .wr_idx(wr_idx), .wr_data(wr_data),
    .fix_en(fix_en), .fix_idx(fix_idx), .add_en(add_en), .add_half(add_half),
    .bank_q(bank_q)
  );

  tr_read_port #(.LANES(LANES), .W(W), .IW(IW)) u_rd (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .bank_q(bank_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/tr_reduce_chk.sv
module tr_reduce_chk #(
  parameter int LANES = 128,
  parameter int CW    = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [CW-1:0] lane_count,
  input logic          busy,
  input logic          done,
  input logic          fix_phase,
  input logic          add_en,
  input logic [CW-1:0] half_q
);
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (lane_count > CW'(1))) |=> busy); // R2

  AST_ADD_AFTER_FIX: assert property (@(posedge clk) disable iff (rst)
    add_en |-> $past(fix_phase)); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R6

  AST_HALF_NONINC: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (half_q <= $past(half_q))); // R7

  AST_TRIVIAL_DONE: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (lane_count <= CW'(1))) |=> (done && !busy)); // R8

  AST_HALF_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (half_q <= CW'(LANES))); // R9
endmodule

bind tree_reduce_top tr_reduce_chk #(.LANES(LANES), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .lane_count(lane_count),
  .busy(busy), .done(done), .fix_phase(fix_phase), .add_en(add_en),
  .half_q(half_q)
);

// File: tb/test_tree_reduce_top.sv
module test_tree_reduce_top;
  localparam int LANES = 16;
  localparam int W     = 16;
  localparam int IW    = 4;
  localparam int CW    = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [W-1:0]  wr_data = '0;
  logic [CW-1:0] lane_count = '0;
  logic          start = 1'b0;
  logic [IW-1:0] rd_idx = '0;
  logic [W-1:0]  rd_data;
  logic          busy;
  logic          done;

  typedef struct {
    logic [W-1:0] sum;
    int           lat;
    int           start_cyc;
  } exp_t;

  exp_t         sb_q[$];
  logic [W-1:0] shadow [LANES];
  int           checks = 0;
  int           errors = 0;
  int           cyc = 0;
  int           mon_cnt = 0;

  tree_reduce_top #(.LANES(LANES), .W(W)) i_tree_reduce_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .lane_count(lane_count), .start(start), .rd_idx(rd_idx),
    .rd_data(rd_data), .busy(busy), .done(done)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic wr(input int idx, input logic [W-1:0] v, input bit track);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    if (track) shadow[idx] = v;
  endtask

  task automatic rd(input int idx, output logic [W-1:0] v);
    @(negedge clk);
    rd_idx = IW'(idx);
    @(negedge clk);
    v = rd_data;
    rd_idx = '0;
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < LANES; i++) wr(i, W'(seed * 37 + i * 1103 + 5), 1'b1);
  endtask

  // Driver: pushes the expected total and latency, then pulses start.
  task automatic run(input int n, input bit disturb);
    exp_t it;
    int eff;
    int h;
    int s;
    int prev;
    logic [W-1:0] v;
    eff = (n > LANES) ? LANES : n;
    it.sum = '0;
    for (int i = 0; i < ((eff < 1) ? 1 : eff); i++) it.sum = it.sum + shadow[i];
    h = eff; s = 0;
    while (h > 1) begin h = h / 2; s++; end
    it.lat = 2 * s;
    prev = mon_cnt;
    @(negedge clk);
    it.start_cyc = cyc + 1;
    sb_q.push_back(it);
    start = 1'b1; lane_count = CW'(n);
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      // R7: second start and a write while busy must be ignored
      lane_count = CW'(3);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wr_en = 1'b1; wr_idx = IW'(LANES - 1); wr_data = 16'hBEEF;
      @(negedge clk);
      wr_en = 1'b0;
    end
    while (mon_cnt == prev) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R7 busy low after done", int'(busy), 0);
    // R5: entry at index N is untouched
    if (eff < LANES && eff >= 1) begin
      rd(eff, v);
      chk("R5 entry above count unchanged", int'(v), int'(shadow[eff]));
    end
  endtask

  // Monitor: pops an expected item at each done and compares.
  initial begin
    exp_t it;
    forever begin
      @(negedge clk);
      if (!rst && done) begin
        if (sb_q.size() == 0) begin
          chk("R6 unexpected done", 1, 0);
        end else begin
          it = sb_q.pop_front();
          chk("R6 done latency", cyc - it.start_cyc, it.lat);
          chk("R7 busy low with done", int'(busy), 0);
          @(negedge clk);
          chk("R6 done single cycle", int'(done), 0);
          chk("R5 total in entry 0", int'(rd_data), int'(it.sum));
        end
        mon_cnt++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    for (int i = 0; i < LANES; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 done after reset", int'(done), 0);
    rd(3, v);
    chk("R1 entry reads zero after reset", int'(v), 0);
    // R1 write and read back
    wr(2, 16'h1234, 1'b1);
    wr(9, 16'hA5A5, 1'b1);
    rd(2, v);
    chk("R1 read back entry 2", int'(v), 16'h1234);
    rd(9, v);
    chk("R1 read back entry 9", int'(v), 16'hA5A5);

    // R2 R4 full power-of-two count
    fill(1); run(16, 1'b0);
    // R3 odd counts exercise the fix-up
    fill(2); run(5, 1'b0);
    fill(3); run(7, 1'b0);
    fill(4); run(2, 1'b0);
    fill(5); run(3, 1'b0);
    // R9 clamp above bank size
    fill(6); run(20, 1'b0);
    // R8 trivial counts
    fill(7); run(1, 1'b0);
    rd(1, v);
    chk("R8 entry 1 unchanged", int'(v), int'(shadow[1]));
    run(0, 1'b0);
    // R7 start and write while busy are ignored
    fill(8); run(12, 1'b1);
    rd(LANES - 1, v);
    chk("R7 write while busy dropped", int'(v), int'(shadow[LANES-1]));
    // R5 wraparound modulo 2^W
    for (int i = 0; i < LANES; i++) wr(i, 16'hF001, 1'b1);
    run(16, 1'b0);
    fill(9); run(11, 1'b0);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule